// File: doc/BRIEF.md
# Data Buffer Level Pacer

This block is a circular word buffer that sits between a host register port and a card-side word stream. The host writes words and the card side pops them when sending. The card side pushes words and the host reads them when receiving. At most one word enters and one word leaves per cycle. The host port takes priority over the card port on each side.

Each cycle the block compares the fill count with two programmable levels, one high-water and one low-water, and takes account of the current transfer direction. In the receive direction, a fill count above the high-water level raises either a receive DMA request or a receive level flag. In the transmit direction, a fill count below the low-water level raises either a transmit DMA request or a transmit level flag. A per-direction DMA enable in the configuration word chooses between the request and the flag. The outputs are registered, so the DMA engine or the interrupt logic sees a stable level.

Top module: `xfer_fifo_pacer`

## Requirements
- R1: The buffer holds up to DEPTH words (32 by default) of WIDTH bits (16 by default). Words leave in the order they entered. `fill_count` runs from 0 to DEPTH, and `head_word` shows the oldest stored word.
- R2: A push (host write or card push) while the buffer holds DEPTH words is dropped. The fill count and the stored words stay unchanged.
- R3: A pop (host read or card pop) on an empty buffer moves no pointer. `head_word` keeps showing the word at the read position, and the next word pushed appears there.
- R4: Configuration word layout: bit 15 enables receive DMA, bits 12:8 set the high-water level, bit 7 enables transmit DMA, and bits 4:0 set the low-water level. After reset both enables are 0, the high-water level is 31 and the low-water level is 0.
- R5: When `rx_dir`=1 and the fill count is above the high-water level, `rx_dma_req`=1 if receive DMA is enabled; otherwise `rx_level_flag`=1. In every other case both are 0.
- R6: When `rx_dir`=0 and the fill count is below the low-water level, `tx_dma_req`=1 if transmit DMA is enabled; otherwise `tx_level_flag`=1. In every other case both are 0.
- R7: When `xfer_active`=0 and the buffer is empty, both flags and both requests are 0.
- R8: A configuration write with bit 15 set forces `rx_level_flag` to 0 in the next cycle. One with bit 7 set forces `tx_level_flag` to 0 in the next cycle.
- R9: Requests and flags are registered. They reflect the fill count, configuration, direction and `xfer_active` as they stood before the previous clock edge, so they follow a fill change by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | A data transfer is in progress |
| rx_dir | input | 1 | 1 = receive (card to host), 0 = transmit |
| hw_wr_en | input | 1 | Host word write strobe |
| hw_wdata | input | WIDTH | Host write word |
| hw_rd_en | input | 1 | Host word read strobe |
| cfg_wr_en | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word |
| cd_push | input | 1 | Card-side push strobe |
| cd_push_data | input | WIDTH | Card-side push word |
| cd_pop | input | 1 | Card-side pop strobe |
| head_word | output | WIDTH | Word at the read position |
| fill_count | output | $clog2(DEPTH)+1 | Words stored |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_level_flag | output | 1 | Receive high-water flag |
| tx_level_flag | output | 1 | Transmit low-water flag |

## Verification
The bench uses the default DEPTH of 32 and WIDTH of 16. At these values the 5-bit level fields reach every fill count. With a high-water level of 31, the receive condition holds only when the buffer is completely full, which puts both the full-drop case and the reset level within a few dozen cycles. A full fill-and-drain also returns the read pointer to slot 0, so the empty-read case has a known expected word.

// File: rtl/xfer_fifo_pacer.sv
module xfer_fifo_pacer #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       xfer_active,
  input  logic                       rx_dir,
  input  logic                       hw_wr_en,
  input  logic [WIDTH-1:0]           hw_wdata,
  input  logic                       hw_rd_en,
  input  logic                       cfg_wr_en,
  input  logic [15:0]                cfg_wdata,
  input  logic                       cd_push,
  input  logic [WIDTH-1:0]           cd_push_data,
  input  logic                       cd_pop,
  output logic [WIDTH-1:0]           head_word,
  output logic [$clog2(DEPTH):0]     fill_count,
  output logic                       rx_dma_req,
  output logic                       tx_dma_req,
  output logic                       rx_level_flag,
  output logic                       tx_level_flag
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  logic       rx_dma_en, tx_dma_en;
  logic [4:0] hi_lvl, lo_lvl;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[14:13], cfg_wdata[6:5]};

  wire push_req = hw_wr_en | cd_push;
  wire pop_req  = hw_rd_en | cd_pop;
  wire push_go  = push_req && (count != FULL);
  wire pop_go   = pop_req && (count != '0);
  wire [WIDTH-1:0] push_word = hw_wr_en ? hw_wdata : cd_push_data;

  assign head_word  = mem[rd_ptr];
  assign fill_count = count;

  always_ff @(posedge clk) begin
    if (push_go) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_go) wr_ptr <= wr_ptr + 1'b1;
      if (pop_go)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_go, pop_go})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
      hi_lvl    <= 5'd31;
      lo_lvl    <= 5'd0;
    end else if (cfg_wr_en) begin
      rx_dma_en <= cfg_wdata[15];
      hi_lvl    <= cfg_wdata[12:8];
      tx_dma_en <= cfg_wdata[7];
      lo_lvl    <= cfg_wdata[4:0];
    end
  end

  wire idle    = !xfer_active && (count == '0);
  wire rx_hit  = !idle && rx_dir && (count > CW'(hi_lvl));
  wire tx_hit  = !idle && !rx_dir && (count < CW'(lo_lvl));
  wire rx_wipe = cfg_wr_en && cfg_wdata[15];
  wire tx_wipe = cfg_wr_en && cfg_wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_dma_req    <= 1'b0;
      tx_dma_req    <= 1'b0;
      rx_level_flag <= 1'b0;
      tx_level_flag <= 1'b0;
    end else begin
      rx_dma_req    <= rx_hit && rx_dma_en;
      rx_level_flag <= rx_hit && !rx_dma_en && !rx_wipe;
      tx_dma_req    <= tx_hit && tx_dma_en;
      tx_level_flag <= tx_hit && !tx_dma_en && !tx_wipe;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= FULL); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL && push_req && !pop_req) |=> ($stable(count) && $stable(wr_ptr))); // R2
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop_req) |=> $stable(rd_ptr)); // R3
  AST_RX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_dma_req && rx_level_flag)); // R5
  AST_RX_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dir |=> (!rx_dma_req && !rx_level_flag)); // R5
  AST_TX_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dir |=> (!tx_dma_req && !tx_level_flag)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && fill_count == '0) |=> (!rx_dma_req && !tx_dma_req && !rx_level_flag && !tx_level_flag)); // R7
  AST_RX_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wdata[15]) |=> !rx_level_flag); // R8
  AST_TX_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wdata[7]) |=> !tx_level_flag); // R8
endmodule

// File: tb/sim_xfer_fifo_pacer.sv
module sim_xfer_fifo_pacer;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0;
  logic xact = 0, rxd = 0;
  logic hw_wr = 0, hw_rd = 0, cdp = 0, cdo = 0, cfgw = 0;
  logic [15:0] hwd = 0, cpd = 0, cfgd = 0;

  logic [15:0] head;
  logic [5:0]  fcnt;
  logic rxreq, txreq, rxf, txf;

  xfer_fifo_pacer u0 (
    .clk(clk), .rst_n(rst_n), .xfer_active(xact), .rx_dir(rxd),
    .hw_wr_en(hw_wr), .hw_wdata(hwd), .hw_rd_en(hw_rd),
    .cfg_wr_en(cfgw), .cfg_wdata(cfgd),
    .cd_push(cdp), .cd_push_data(cpd), .cd_pop(cdo),
    .head_word(head), .fill_count(fcnt),
    .rx_dma_req(rxreq), .tx_dma_req(txreq),
    .rx_level_flag(rxf), .tx_level_flag(txf)
  );

  int checks = 0, fails = 0;
  int mq[$];
  bit m_rxen = 0, m_txen = 0;
  int m_af = 31, m_ae = 0;
  bit e_rxreq = 0, e_txreq = 0, e_rxf = 0, e_txf = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1 fill count", int'(fcnt), mq.size());
    if (mq.size() > 0) check("R1 head word order", int'(head), mq[0]);
    check("R5 rx request", int'(rxreq), int'(e_rxreq));
    check("R5 rx flag", int'(rxf), int'(e_rxf));
    check("R6 tx request", int'(txreq), int'(e_txreq));
    check("R6 tx flag", int'(txf), int'(e_txf));
  endtask

  task automatic tick();
    int cnt;
    bit idle, rxc, txc, pushok, popok;
    int pw;
    @(posedge clk);
    cnt  = mq.size();
    idle = !xact && cnt == 0;
    rxc  = rxd && cnt > m_af;
    txc  = !rxd && cnt < m_ae;
    e_rxreq = !idle && rxc && m_rxen;
    e_rxf   = !idle && rxc && !m_rxen && !(cfgw && cfgd[15]);
    e_txreq = !idle && txc && m_txen;
    e_txf   = !idle && txc && !m_txen && !(cfgw && cfgd[7]);
    pushok = (hw_wr || cdp) && cnt < 32;
    popok  = (hw_rd || cdo) && cnt > 0;
    pw = hw_wr ? int'(hwd) : int'(cpd);
    if (popok) void'(mq.pop_front());
    if (pushok) mq.push_back(pw);
    if (cfgw) begin
      m_rxen = cfgd[15]; m_af = int'(cfgd[12:8]);
      m_txen = cfgd[7];  m_ae = int'(cfgd[4:0]);
    end
    @(negedge clk);
    compare_all();
    hw_wr = 0; hw_rd = 0; cdp = 0; cdo = 0; cfgw = 0;
  endtask

  task automatic host_write(int v); hw_wr = 1; hwd = 16'(v); tick(); endtask
  task automatic host_read(); hw_rd = 1; tick(); endtask
  task automatic card_push(int v); cdp = 1; cpd = 16'(v); tick(); endtask
  task automatic card_pop(); cdo = 1; tick(); endtask
  task automatic cfg_write(int v); cfgw = 1; cfgd = 16'(v); tick(); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset fill", int'(fcnt), 0);
    check("R4 reset outputs", int'({rxreq, txreq, rxf, txf}), 0);
    rst_n = 1;
    xact = 1; rxd = 1;

    // default high-water 31: flag only when full
    for (int i = 0; i < 31; i++) host_write(16'h1000 + i);
    tick();
    check("R4 hi level 31 not yet", int'(rxf), 0);
    host_write(16'h101F);
    tick();
    check("R4 hi level 31 full", int'(rxf), 1);
    host_write(16'hDEAD);
    check("R2 full drop count", int'(fcnt), 32);
    check("R2 full drop head", int'(head), 16'h1000);
    for (int i = 0; i < 32; i++) host_read();
    tick();

    // empty read: pointer back at slot 0
    check("R3 empty head", int'(head), 16'h1000);
    host_read();
    check("R3 empty read count", int'(fcnt), 0);
    check("R3 empty read head", int'(head), 16'h1000);
    card_pop();
    card_push(16'h5A5A);
    check("R3 push lands at read slot", int'(head), 16'h5A5A);
    host_read();

    // receive path with high-water 4
    cfg_write(16'h0400);
    for (int i = 0; i < 4; i++) card_push(16'h2000 + i);
    tick();
    check("R5 at level no flag", int'(rxf), 0);
    card_push(16'h2004);
    check("R9 flag lags fill", int'(rxf), 0);
    tick();
    check("R9 flag after one cycle", int'(rxf), 1);
    card_push(16'h2005);
    cfg_write(16'h8400);
    check("R8 rx flag wiped", int'(rxf), 0);
    tick();
    check("R5 rx request", int'(rxreq), 1);
    cfg_write(16'h0400);
    tick();
    check("R5 flag returns", int'(rxf), 1);
    rxd = 0;
    tick();
    check("R5 direction gates rx", int'({rxreq, rxf}), 0);
    for (int i = 0; i < 6; i++) host_read();

    // transmit path with low-water 8
    cfg_write(16'h0008);
    tick();
    check("R6 empty below level flag", int'(txf), 1);
    for (int i = 0; i < 8; i++) host_write(16'h3000 + i);
    tick();
    check("R6 at level clear", int'(txf), 0);
    cfg_write(16'h0088);
    for (int i = 0; i < 5; i++) card_pop();
    tick();
    check("R6 tx request", int'(txreq), 1);
    check("R6 tx flag off with dma", int'(txf), 0);
    hw_wr = 1; hwd = 16'h3100; hw_rd = 1; tick();
    cfg_write(16'h0008);
    tick();
    check("R6 tx flag back", int'(txf), 1);
    cfg_write(16'h0088);
    check("R8 tx flag wiped", int'(txf), 0);

    // idle: no transfer and empty
    xact = 0;
    while (mq.size() > 0) card_pop();
    tick(); tick();
    check("R7 idle quiet", int'({rxreq, txreq, rxf, txf}), 0);
    rxd = 1; cfg_write(16'h0000);
    tick(); tick();
    check("R7 idle quiet rx", int'({rxreq, txreq, rxf, txf}), 0);

    finish_run();
  end
endmodule